// File: doc/BRIEF.md
# Halfword-Swapping DMA Data Path

This block is the streaming data path of an Ethernet DMA channel. It sits between a 16-bit peripheral data bus and byte-addressed system memory. Each transfer starts with a request that carries a peripheral address, a byte length, a direction and a flag that turns swapping off. The block forms the memory address by OR-ing a base-address value into the peripheral address. It then issues memory commands and moves the data one beat at a time through a lane that can exchange the two bytes of each halfword.

When swapping is active, the low bit of both the address and the length is cleared before anything else happens, and every halfword has its bytes exchanged. Writes toward memory are also cut into bursts of at most `MAX_BURST` bytes, with the address moving forward by each burst's size. When the bypass flag is set, the address and length are used exactly as given, the data passes unchanged, and one command covers the whole transfer. Reads from memory always use a single command. A one-cycle done pulse marks the end of each request.

Top module: `hsw_dma_path`

## Requirements
- R1: The address of the first memory command equals `req_addr | base_addr`, with bit 0 cleared when swapping is active.
- R2: With `req_bypass`=1, `dst_data` equals `src_data` on every beat, and the address and byte count are not aligned, so odd values remain odd.
- R3: With `req_bypass`=0, every command address has bit 0 = 0, and the total byte count is `req_len` with bit 0 cleared.
- R4: With `req_bypass`=0, each beat leaves as `{src_data[7:0], src_data[15:8]}`, in both directions.
- R5: A swapped write (`req_write`=1, `req_bypass`=0) is issued as commands of `min(remaining, 64)` bytes. Each command address is the previous address plus the previous byte count. `cmd_addr` and `cmd_bytes` stay stable while `cmd_valid` is waiting for `cmd_ready`.
- R6: A read (`req_write`=0) and a bypassed write are each issued as one command that covers the whole length. `cmd_write` follows `req_write`.
- R7: A request whose length is zero after alignment issues no command and no data beat. It raises `done` in the cycle after it is accepted.
- R8: When `dst_ready`=0, `src_ready` is 0, and a pending `dst_valid` beat stays stable, so no halfword is lost or repeated. The transfer carries ceil(length/2) beats.
- R9: `done` is high for exactly one cycle. It follows the edge at which both the last beat and the last command have been accepted.
- R10: While a transfer is in progress, `req_ready`=0 and any request presented is ignored.
- R11: After reset, `req_ready`=1, and `cmd_valid`, `dst_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | AW | Base address OR-ed into the request address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Peripheral-side byte address |
| req_len | input | LW | Transfer length in bytes |
| req_write | input | 1 | 1 = toward memory, 0 = from memory |
| req_bypass | input | 1 | 1 = no swap and no alignment |
| src_valid | input | 1 | Input beat valid |
| src_ready | output | 1 | Input beat taken |
| src_data | input | DW | Input beat |
| dst_valid | output | 1 | Output beat valid |
| dst_ready | input | 1 | Output beat taken |
| dst_data | output | DW | Output beat, swapped or unchanged |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command taken |
| cmd_addr | output | AW | Memory command byte address |
| cmd_bytes | output | LW | Memory command byte count |
| cmd_write | output | 1 | Memory command direction |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Suppose the burst cursor holds a wrong remaining count. The next command then shows a wrong `cmd_bytes` or `cmd_addr` at the port in the cycle it is offered. The done pulse also moves early or late against the final beat. Suppose the beat counter is wrong. The done pulse then arrives before the expected number of beats has passed, or the data stream overruns it, within the same request. A fault in the swap lane or in the mode register corrupts the first data beat of the next request it touches. A fault in the alignment logic shows in the first command's address or size.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   // Operating mode captured when a request is accepted
   typedef struct packed {
      logic to_mem;   // transfer direction toward memory
      logic swap;     // byte exchange and halfword alignment active
   } hsw_mode_t;

endpackage

// File: rtl/hsw_req_align.sv
// Forms the effective address, aligned byte count and beat count of a request.
module hsw_req_align #(
   parameter int AW  = 32,
   parameter int LW  = 12,
   parameter int BPB = 2
) (
   input  logic [AW-1:0] addr_in,
   input  logic [AW-1:0] base_in,
   input  logic [LW-1:0] len_in,
   input  logic          bypass_in,
   output logic [AW-1:0] addr_out,
   output logic [LW-1:0] len_out,
   output logic [LW-1:0] beats_out
);
   localparam int SH = $clog2(BPB);

   logic [AW-1:0] merged;
   logic [LW:0]   rounded;

   always_comb begin
      merged   = addr_in | base_in;
      addr_out = merged;
      len_out  = len_in;
      if (!bypass_in) begin
         addr_out[0] = 1'b0;
         len_out[0]  = 1'b0;
      end
      rounded   = {1'b0, len_out} + (LW+1)'(BPB - 1);
      beats_out = LW'(rounded >> SH);
   end
endmodule

// File: rtl/hsw_burst_gen.sv
// Issues memory commands for one request, optionally capped in size.
module hsw_burst_gen #(
   parameter int AW        = 32,
   parameter int LW        = 12,
   parameter int MAX_BURST = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [LW-1:0] load_len,
   input  logic          load_cap,
   output logic          cmd_valid,
   input  logic          cmd_ready,
   output logic [AW-1:0] cmd_addr,
   output logic [LW-1:0] cmd_bytes,
   output logic          cmds_finish
);
   localparam logic [LW-1:0] CAP = LW'(MAX_BURST);

   logic [AW-1:0] cur_addr_q;
   logic [LW-1:0] rem_q;
   logic          cap_q;
   logic [LW-1:0] size;
   logic [LW-1:0] rem_after;
   logic          fire;

   always_comb begin
      size      = (cap_q && rem_q > CAP) ? CAP : rem_q;
      fire      = cmd_valid && cmd_ready;
      rem_after = fire ? rem_q - size : rem_q;
   end

   assign cmd_valid   = (rem_q != '0);
   assign cmd_addr    = cur_addr_q;
   assign cmd_bytes   = size;
   assign cmds_finish = (rem_after == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr_q <= '0;
         rem_q      <= '0;
         cap_q      <= 1'b0;
      end else if (load) begin
         cur_addr_q <= load_addr;
         rem_q      <= load_len;
         cap_q      <= load_cap;
      end else if (fire) begin
         cur_addr_q <= cur_addr_q + AW'(size);
         rem_q      <= rem_after;
      end
   end
endmodule

// File: rtl/hsw_swap_lane.sv
// Exchanges the two bytes of each halfword of a beat when enabled.
module hsw_swap_lane #(
   parameter int DW = 16
) (
   input  logic          swap_en,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   localparam int NH = DW / 16;

   logic [DW-1:0] swapped;

   for (genvar h = 0; h < NH; h++) begin : g_half
      assign swapped[h*16 +: 8]     = din[h*16 + 8 +: 8];
      assign swapped[h*16 + 8 +: 8] = din[h*16 +: 8];
   end

   assign dout = swap_en ? swapped : din;
endmodule

// File: rtl/hsw_dma_path.sv
// Halfword-swapping DMA data path: request alignment, burst split, swap lane.
module hsw_dma_path
   import hsw_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LW        = 12,
   parameter int DW        = 16,
   parameter int MAX_BURST = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base_addr,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic          req_write,
   input  logic          req_bypass,
   input  logic          src_valid,
   output logic          src_ready,
   input  logic [DW-1:0] src_data,
   output logic          dst_valid,
   input  logic          dst_ready,
   output logic [DW-1:0] dst_data,
   output logic          cmd_valid,
   input  logic          cmd_ready,
   output logic [AW-1:0] cmd_addr,
   output logic [LW-1:0] cmd_bytes,
   output logic          cmd_write,
   output logic          done
);
   localparam int BPB = DW / 8;

   if (DW < 16 || (DW % 16) != 0) begin : g_bad_dw
      $error("hsw_dma_path: DW must be a multiple of 16");
   end
   if (MAX_BURST < BPB || (MAX_BURST % BPB) != 0) begin : g_bad_burst
      $error("hsw_dma_path: MAX_BURST must be a multiple of the beat size");
   end
   if (MAX_BURST >= (1 << LW)) begin : g_bad_lw
      $error("hsw_dma_path: MAX_BURST must fit the length field");
   end

   logic          busy_q;
   logic          done_q;
   hsw_mode_t     mode_q;
   logic [LW-1:0] beats_q;

   logic [AW-1:0] al_addr;
   logic [LW-1:0] al_len;
   logic [LW-1:0] al_beats;
   logic          accept;
   logic          zero_len;
   logic          beat_fire;
   logic [LW-1:0] beats_after;
   logic          cmds_finish;
   logic          beats_left;

   hsw_req_align #(.AW(AW), .LW(LW), .BPB(BPB)) u_align (
      .addr_in   (req_addr),
      .base_in   (base_addr),
      .len_in    (req_len),
      .bypass_in (req_bypass),
      .addr_out  (al_addr),
      .len_out   (al_len),
      .beats_out (al_beats)
   );

   assign req_ready = !busy_q;
   assign accept    = req_valid && req_ready;
   assign zero_len  = (al_len == '0);

   hsw_burst_gen #(.AW(AW), .LW(LW), .MAX_BURST(MAX_BURST)) u_burst (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (accept && !zero_len),
      .load_addr   (al_addr),
      .load_len    (al_len),
      .load_cap    (req_write && !req_bypass),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_addr    (cmd_addr),
      .cmd_bytes   (cmd_bytes),
      .cmds_finish (cmds_finish)
   );

   hsw_swap_lane #(.DW(DW)) u_lane (
      .swap_en (mode_q.swap),
      .din     (src_data),
      .dout    (dst_data)
   );

   assign beats_left  = busy_q && (beats_q != '0);
   assign dst_valid   = beats_left && src_valid;
   assign src_ready   = beats_left && dst_ready;
   assign beat_fire   = dst_valid && dst_ready;
   assign beats_after = beats_q - LW'(beat_fire);
   assign cmd_write   = mode_q.to_mem;
   assign done        = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         mode_q  <= '0;
         beats_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q      <= !zero_len;
            done_q      <= zero_len;
            mode_q.to_mem <= req_write;
            mode_q.swap   <= !req_bypass;
            beats_q     <= al_beats;
         end else if (busy_q) begin
            beats_q <= beats_after;
            if (cmds_finish && beats_after == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hsw_dma_path_chk.sv
// Protocol checker for hsw_dma_path, attached by bind below.
module hsw_dma_path_chk #(
   parameter int AW        = 32,
   parameter int LW        = 12,
   parameter int DW        = 16,
   parameter int MAX_BURST = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          src_ready,
   input logic          dst_valid,
   input logic          dst_ready,
   input logic [DW-1:0] dst_data,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [AW-1:0] cmd_addr,
   input logic [LW-1:0] cmd_bytes,
   input logic          cmd_write,
   input logic          swap_on,
   input logic          done
);
   // R3
   a_r3_aligned_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && swap_on |-> !cmd_addr[0] && !cmd_bytes[0]);

   // R5
   a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && swap_on && cmd_write |-> cmd_bytes <= LW'(MAX_BURST) && cmd_bytes != '0);

   a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_bytes));

   // R8
   a_r8_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_ready |-> !src_ready);

   a_r8_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid && !dst_ready |=> dst_valid && $stable(dst_data));

   // R9
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid && !dst_valid);

   // R10
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid || dst_valid) |-> !req_ready);
endmodule

bind hsw_dma_path hsw_dma_path_chk #(
   .AW(AW), .LW(LW), .DW(DW), .MAX_BURST(MAX_BURST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .src_ready (src_ready),
   .dst_valid (dst_valid),
   .dst_ready (dst_ready),
   .dst_data  (dst_data),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_addr  (cmd_addr),
   .cmd_bytes (cmd_bytes),
   .cmd_write (cmd_write),
   .swap_on   (mode_q.swap),
   .done      (done)
);

// File: tb/tb_hsw_dma_path.sv
module tb_hsw_dma_path;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] base_addr;
   logic        req_valid, req_ready;
   logic [31:0] req_addr;
   logic [11:0] req_len;
   logic        req_write, req_bypass;
   logic        src_valid, src_ready;
   logic [15:0] src_data;
   logic        dst_valid, dst_ready;
   logic [15:0] dst_data;
   logic        cmd_valid, cmd_ready;
   logic [31:0] cmd_addr;
   logic [11:0] cmd_bytes;
   logic        cmd_write;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #(CLK_P/2) clk = ~clk;

   hsw_dma_path dut (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_len(req_len), .req_write(req_write), .req_bypass(req_bypass),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_bytes(cmd_bytes), .cmd_write(cmd_write), .done(done)
   );

   typedef struct packed {
      logic        w;
      logic        byp;
      logic        stall;
      logic [31:0] a;
      logic [31:0] b;
      logic [11:0] l;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 32'h0000_1001, 32'h4000_0000, 12'd10},
      '{1'b1, 1'b0, 1'b1, 32'h0000_0200, 32'h1000_0000, 12'd150},
      '{1'b0, 1'b0, 1'b0, 32'h0000_0300, 32'h0000_0001, 12'd150},
      '{1'b1, 1'b1, 1'b0, 32'h0000_0005, 32'h8000_0000, 12'd7},
      '{1'b0, 1'b1, 1'b1, 32'h0000_0011, 32'h0000_0000, 12'd3},
      '{1'b1, 1'b0, 1'b1, 32'h0000_1003, 32'h0000_0020, 12'd129},
      '{1'b1, 1'b0, 1'b0, 32'h0000_0040, 32'h0000_0000, 12'd64}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int i);
      return {8'(i * 7 + 8'h31), 8'(i * 13 + 8'hC2)};
   endfunction

   task automatic run_req(input logic w, input logic byp, input logic stall, input logic hold,
                          input logic [31:0] a, input logic [31:0] b, input logic [11:0] l);
      logic [31:0] ea;
      logic [11:0] el;
      logic [31:0] cur;
      int          rem;
      int          nbeats;
      int          idx;
      int          ncmd;
      int          guard;
      bit          r10_done;
      logic [15:0] ed;
      int          sz;
      ea = a | b;
      el = l;
      if (!byp) begin
         ea[0] = 1'b0;
         el[0] = 1'b0;
      end
      nbeats   = (int'(el) + 1) / 2;
      cur      = ea;
      rem      = int'(el);
      idx      = 0;
      ncmd     = 0;
      guard    = 0;
      r10_done = 1'b0;
      @(negedge clk);
      base_addr  = b;
      req_addr   = a;
      req_len    = l;
      req_write  = w;
      req_bypass = byp;
      req_valid  = 1'b1;
      @(posedge clk);
      #1;
      if (hold) begin
         req_addr  = 32'hFFFF_FFF0;
         req_len   = 12'd40;
         req_write = ~w;
         req_bypass = ~byp;
      end else begin
         req_valid = 1'b0;
      end
      while (1) begin
         if (done) break;
         if (hold && !r10_done) begin
            chk(req_ready == 1'b0, "R10 req_ready while busy", 64'(req_ready), 64'd0);
            r10_done = 1'b1;
         end
         guard++;
         if (guard > 3000) begin
            chk(1'b0, "R9 done never raised", 64'd0, 64'd1);
            break;
         end
         @(negedge clk);
         cyc++;
         cmd_ready = stall ? (cyc % 3 != 1) : 1'b1;
         dst_ready = stall ? (cyc % 4 != 2) : 1'b1;
         src_valid = 1'b1;
         src_data  = pat(idx);
         #1;
         if (cmd_valid && cmd_ready) begin
            if (rem == 0) begin
               chk(1'b0, "R5 extra command", 64'(cmd_bytes), 64'd0);
            end else begin
               sz = (w && !byp && rem > 64) ? 64 : rem;
               chk(cmd_addr == cur, (ncmd == 0) ? "R1 first cmd_addr" : "R5 cmd_addr step",
                   64'(cmd_addr), 64'(cur));
               chk(int'(cmd_bytes) == sz, (w && !byp) ? "R5 burst size" : "R6 single command size",
                   64'(cmd_bytes), 64'(sz));
               chk(cmd_write == w, "R6 cmd_write", 64'(cmd_write), 64'(w));
               cur = cur + 32'(sz);
               rem = rem - sz;
               ncmd++;
            end
         end
         if (!dst_ready) begin
            chk(src_ready == 1'b0, "R8 src_ready under stall", 64'(src_ready), 64'd0);
         end
         if (dst_valid && dst_ready) begin
            ed = byp ? pat(idx) : {pat(idx)[7:0], pat(idx)[15:8]};
            chk(dst_data == ed, byp ? "R2 bypass data" : "R4 swapped data", 64'(dst_data), 64'(ed));
            idx++;
         end
         @(posedge clk);
         #1;
      end
      req_valid = 1'b0;
      src_valid = 1'b0;
      chk(rem == 0, "R3 total bytes covered", 64'(rem), 64'd0);
      chk(idx == nbeats, "R8 beat count at done", 64'(idx), 64'(nbeats));
      if (el == 12'd0) begin
         chk(ncmd == 0, "R7 no command for zero length", 64'(ncmd), 64'd0);
      end
      @(posedge clk);
      #1;
      chk(done == 1'b0, "R9 done lasts one cycle", 64'(done), 64'd0);
      chk(req_ready == 1'b1, "R10 ready again after done", 64'(req_ready), 64'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      base_addr  = '0;
      req_valid  = 1'b0;
      req_addr   = '0;
      req_len    = '0;
      req_write  = 1'b0;
      req_bypass = 1'b0;
      src_valid  = 1'b0;
      src_data   = '0;
      dst_ready  = 1'b1;
      cmd_ready  = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      chk(req_ready == 1'b1, "R11 req_ready in reset", 64'(req_ready), 64'd1);
      chk(cmd_valid == 1'b0, "R11 cmd_valid in reset", 64'(cmd_valid), 64'd0);
      chk(dst_valid == 1'b0, "R11 dst_valid in reset", 64'(dst_valid), 64'd0);
      chk(done == 1'b0, "R11 done in reset", 64'(done), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(cmd_valid == 1'b0 && done == 1'b0, "R11 quiet after reset", 64'({cmd_valid, done}), 64'd0);

      for (int i = 0; i < NV; i++) begin
         run_req(VECS[i].w, VECS[i].byp, VECS[i].stall, 1'b0, VECS[i].a, VECS[i].b, VECS[i].l);
      end

      // R7: swapped length 1 aligns to zero
      run_req(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 32'h0, 12'd1);
      // R7: bypassed length 0
      run_req(1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0100, 32'h0, 12'd0);
      // R10: request held high during a transfer is ignored
      run_req(1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0800, 32'h0300_0000, 12'd140);
      // R2: bypassed write of a single odd byte
      run_req(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0010, 12'd1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule